// File: doc/BRIEF.md
# Saturating Fixed-Point Scalar Coprocessor

This block is a scalar execution engine that sits beside a host processor and runs the saturating 16/32-bit primitives that fixed-point speech codecs lean on. These are fractional multiply, multiply-accumulate, saturating add and subtract, two-way shifts, absolute value, negation and normalisation count. The host decodes the instruction and presents one operation per cycle: an opcode, a destination register and two source registers from a private file of 16 words of 32 bits. The host may also supply a 32-bit word for loads into the file. A single sticky overflow flag records that some operation since the last clear had to clamp its result.

Execution spans two pipeline stages. The first stage reads the operands, with forwarding. It also forms the doubled 16×16 product, the shift result and the single-operand results. The second stage performs the 32-bit add or subtract for the additive operations, saturates the result and commits it to the register file. If the instruction asks for a return to the host, the second stage instead presents the result on the output port. Moving data into the file and reading it back are ordinary operations, so they use the same pipeline and the same forwarding.

Top module: `itu_sat_cop`

## Requirements
- R1: After reset the overflow flag is 0, the result-valid output is 0 and every register of the file reads as zero.
- R2: Opcode 1 (load) writes the data input to the destination, and opcode 0 (move) copies source A to the destination.
- R3: Opcode 2 (add) computes A+B and opcode 3 (subtract) computes A−B, in 32-bit two's complement. A result above 0x7FFFFFFF becomes 0x7FFFFFFF and one below 0x80000000 becomes 0x80000000. Each such clamp sets the overflow flag.
- R4: Opcode 4 (multiply) treats bits 15:0 of A and of B as signed and returns twice their product. When both halves are 0x8000 the result is 0x7FFFFFFF and the overflow flag is set.
- R5: Opcode 5 (multiply-accumulate) computes D + 2·A·B and opcode 6 (multiply-subtract) computes D − 2·A·B. D is the current content of the destination register. The doubled product saturates as in R4, and the sum or difference then saturates as in R3. Either clamp sets the flag.
- R6: Opcode 7 shifts A left by the signed count in bits 15:0 of B, and opcode 8 shifts A right by that count. A negative count reverses the direction. Right shifts are arithmetic, and any count of 31 or more leaves only sign bits. Left shifts that lose significant bits saturate to 0x7FFFFFFF or 0x80000000 according to the sign of A and set the flag.
- R7: Opcode 9 returns |A| and opcode 10 returns −A, each mapping 0x80000000 to 0x7FFFFFFF and setting the flag. Opcode 11 returns the count of redundant sign bits of A, which is 0 for A = 0 and 31 for A = 0xFFFFFFFF.
- R8: The overflow flag stays set until the clear input is asserted. A clear in the same cycle as a new clamp leaves the flag set.
- R9: An operation issued at clock edge k takes effect at edge k+2. With the return bit clear, the destination register is updated at that edge. With the return bit set, the result-valid output is high for one cycle with the result and the register file is left unchanged.
- R10: An operation may read a register written by the operation issued one cycle earlier and obtains the new value.
- R11: Opcodes 12 to 15 write no register, return nothing and leave the overflow flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vld_i | input | 1 | Operation present this cycle |
| op_i | input | 4 | Opcode |
| dst_i | input | 4 | Destination register, also accumulator source |
| sa_i | input | 4 | Source A register |
| sb_i | input | 4 | Source B register |
| ret_i | input | 1 | Return the result to the host instead of writing it |
| din_i | input | 32 | Data for the load opcode |
| ovf_clr_i | input | 1 | Clear the sticky overflow flag |
| ovf_o | output | 1 | Sticky overflow flag |
| rvld_o | output | 1 | Returned result valid |
| rdata_o | output | 32 | Returned result |

## Verification
Every computing opcode is swept over all ordered pairs of a ten-value set of extremes: zero, ±1, the two 32-bit limits, the 16-bit limits in the low half, 0x40000000, −32 and 33. The accumulator value rotates through the same set. This separates exact results from those clamped at either limit. It also exercises product saturation before and after the accumulation, and shift counts that are negative, zero, in range or too large. The order of the three loads before each operation alternates, so both source and accumulator reads pass through forwarding and through the register file. Directed sequences cover flag persistence, the clear racing a new clamp, return without write-back and the reserved opcodes.

// File: rtl/itu_sat_cop.sv
module itu_sat_cop #(
  parameter int NREG = 16,
  localparam int AW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld_i,
  input  logic [3:0]    op_i,
  input  logic [AW-1:0] dst_i,
  input  logic [AW-1:0] sa_i,
  input  logic [AW-1:0] sb_i,
  input  logic          ret_i,
  input  logic [31:0]   din_i,
  input  logic          ovf_clr_i,
  output logic          ovf_o,
  output logic          rvld_o,
  output logic [31:0]   rdata_o
);
  localparam logic [3:0] OP_MOV = 4'd0, OP_LDI = 4'd1, OP_ADD = 4'd2, OP_SUB = 4'd3,
                         OP_MUL = 4'd4, OP_MAC = 4'd5, OP_MSU = 4'd6, OP_SHL = 4'd7,
                         OP_SHR = 4'd8, OP_ABS = 4'd9, OP_NEG = 4'd10, OP_NRM = 4'd11;
  localparam logic [31:0] MAXV = 32'h7FFF_FFFF, MINV = 32'h8000_0000;

  logic [31:0] rf [NREG];

  logic          s1_vld, s1_ret, s1_ov;
  logic [3:0]    s1_op;
  logic [AW-1:0] s1_dst;
  logic [31:0]   s1_x, s1_y;

  logic [32:0] sum;
  logic        is_arith, is_sub, aov, s2_wr, s2_ov;
  logic [31:0] s2_res;

  assign is_sub   = (s1_op == OP_SUB) || (s1_op == OP_MSU);
  assign is_arith = is_sub || (s1_op == OP_ADD) || (s1_op == OP_MAC);
  assign sum      = is_sub ? ({s1_x[31], s1_x} - {s1_y[31], s1_y})
                           : ({s1_x[31], s1_x} + {s1_y[31], s1_y});
  assign aov      = is_arith && (sum[32] != sum[31]);
  assign s2_res   = aov ? (sum[32] ? MINV : MAXV) : (is_arith ? sum[31:0] : s1_x);
  assign s2_ov    = s1_vld && (s1_ov || aov);
  assign s2_wr    = s1_vld && !s1_ret;

  function automatic logic [31:0] fwd(input logic [AW-1:0] idx, input logic wr,
                                      input logic [AW-1:0] widx, input logic [31:0] wval,
                                      input logic [31:0] rval);
    return (wr && widx == idx) ? wval : rval;
  endfunction

  logic [31:0] a, b, d;
  assign a = fwd(sa_i,  s2_wr, s1_dst, s2_res, rf[sa_i]);
  assign b = fwd(sb_i,  s2_wr, s1_dst, s2_res, rf[sb_i]);
  assign d = fwd(dst_i, s2_wr, s1_dst, s2_res, rf[dst_i]);

  logic signed [31:0] prod;
  logic        mul_sat;
  logic [31:0] mul_r;
  assign prod    = $signed(a[15:0]) * $signed(b[15:0]);
  assign mul_sat = (a[15:0] == 16'h8000) && (b[15:0] == 16'h8000);
  assign mul_r   = mul_sat ? MAXV : {prod[30:0], 1'b0};

  logic [16:0] mag;
  logic        go_left, lov;
  logic [5:0]  lamt;
  logic [4:0]  ramt;
  logic [63:0] wide;
  logic [31:0] lres, rres;
  assign mag     = b[15] ? (17'd0 - {b[15], b[15:0]}) : {1'b0, b[15:0]};
  assign go_left = (op_i == OP_SHL) ^ b[15];
  assign lamt    = (mag > 17'd32) ? 6'd32 : mag[5:0];
  assign ramt    = (mag > 17'd31) ? 5'd31 : mag[4:0];
  assign wide    = {{32{a[31]}}, a} << lamt;
  assign lov     = !((&wide[63:31]) || !(|wide[63:31]));
  assign lres    = lov ? (a[31] ? MINV : MAXV) : wide[31:0];
  assign rres    = $unsigned($signed(a) >>> ramt);

  logic [31:0] nrm;
  always_comb begin
    logic stop;
    nrm  = '0;
    stop = 1'b0;
    for (int i = 30; i >= 0; i--) begin
      if (!stop && a[i] == a[31]) nrm = nrm + 32'd1;
      else stop = 1'b1;
    end
    if (a == '0) nrm = '0;
  end

  logic [31:0] x1, y1;
  logic        ov1;
  always_comb begin
    x1  = a;
    y1  = b;
    ov1 = 1'b0;
    case (op_i)
      OP_LDI: x1 = din_i;
      OP_MUL: begin x1 = mul_r; ov1 = mul_sat; end
      OP_MAC, OP_MSU: begin x1 = d; y1 = mul_r; ov1 = mul_sat; end
      OP_SHL, OP_SHR: begin x1 = go_left ? lres : rres; ov1 = go_left && lov; end
      OP_ABS: begin x1 = (a == MINV) ? MAXV : (a[31] ? 32'd0 - a : a); ov1 = (a == MINV); end
      OP_NEG: begin x1 = (a == MINV) ? MAXV : 32'd0 - a; ov1 = (a == MINV); end
      OP_NRM: x1 = nrm;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld <= 1'b0;
      s1_ret <= 1'b0;
      s1_ov  <= 1'b0;
      s1_op  <= OP_MOV;
      s1_dst <= '0;
      s1_x   <= '0;
      s1_y   <= '0;
    end else begin
      s1_vld <= vld_i && (op_i <= OP_NRM);
      s1_ret <= ret_i;
      s1_ov  <= ov1;
      s1_op  <= op_i;
      s1_dst <= dst_i;
      s1_x   <= x1;
      s1_y   <= y1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
      ovf_o   <= 1'b0;
      rvld_o  <= 1'b0;
      rdata_o <= '0;
    end else begin
      if (s2_wr) rf[s1_dst] <= s2_res;
      ovf_o  <= (ovf_o && !ovf_clr_i) || s2_ov;
      rvld_o <= s1_vld && s1_ret;
      if (s1_vld && s1_ret) rdata_o <= s2_res;
    end
  end

  // R8
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o && !ovf_clr_i |=> ovf_o);
  // R8
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld && s1_ov |=> ovf_o);
  // R4
  mul_lim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i && op_i == OP_MUL && a[15:0] == 16'h8000 && b[15:0] == 16'h8000
    |=> s1_vld && s1_ov && s1_x == MAXV);
  // R9
  ret_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld && s1_ret |=> rvld_o);
  // R11
  rsv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i && op_i > OP_NRM |=> !s1_vld);
  // R9
  rvld_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_vld |=> !rvld_o);
endmodule

// File: tb/itu_sat_cop_tb.sv
module itu_sat_cop_tb_top;
  localparam time TCLK = 10ns;
  localparam longint MAXL = 64'sd2147483647, MINL = -64'sd2147483648;

  logic clk = 1'b0, rst_n = 1'b0;
  logic vld_i = 0, ret_i = 0, ovf_clr_i = 0;
  logic [3:0] op_i = 0, dst_i = 0, sa_i = 0, sb_i = 0;
  logic [31:0] din_i = 0;
  logic ovf_o, rvld_o;
  logic [31:0] rdata_o;
  int errors = 0, checks = 0;

  always #(TCLK/2) clk = ~clk;

  itu_sat_cop dut_i (.clk, .rst_n, .vld_i, .op_i, .dst_i, .sa_i, .sb_i, .ret_i,
                     .din_i, .ovf_clr_i, .ovf_o, .rvld_o, .rdata_o);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] satf(input longint v, inout bit ov);
    if (v > MAXL) begin ov = 1; return 32'h7FFFFFFF; end
    if (v < MINL) begin ov = 1; return 32'h80000000; end
    return v[31:0];
  endfunction

  function automatic longint sx(input logic [31:0] v);
    return longint'($signed(v));
  endfunction

  function automatic logic [31:0] lm(input logic [31:0] a, input logic [31:0] b, inout bit ov);
    longint p = longint'($signed(a[15:0])) * longint'($signed(b[15:0])) * 2;
    return satf(p, ov);
  endfunction

  function automatic logic [31:0] shf(input logic [31:0] a, input int n, inout bit ov);
    if (n >= 32) begin
      if (a == 0) return 0;
      ov = 1;
      return a[31] ? 32'h80000000 : 32'h7FFFFFFF;
    end
    if (n >= 0) return satf(sx(a) * (64'sd1 <<< n), ov);
    begin
      longint r = sx(a) >>> ((-n > 31) ? 31 : -n);
      return r[31:0];
    end
  endfunction

  function automatic logic [31:0] nrmf(input logic [31:0] a);
    logic [31:0] t;
    int n = 0;
    if (a == 0) return 0;
    t = a[31] ? ~a : a;
    while (t < 32'h40000000 && n < 31) begin t = t << 1; n++; end
    return n;
  endfunction

  function automatic logic [31:0] model(input logic [3:0] op, input logic [31:0] a,
                                        input logic [31:0] b, input logic [31:0] d, output bit ov);
    int cnt = int'($signed(b[15:0]));
    logic [31:0] m;
    ov = 0;
    case (op)
      0, 1: return a;
      2: return satf(sx(a) + sx(b), ov);
      3: return satf(sx(a) - sx(b), ov);
      4: return lm(a, b, ov);
      5: begin m = lm(a, b, ov); return satf(sx(d) + sx(m), ov); end
      6: begin m = lm(a, b, ov); return satf(sx(d) - sx(m), ov); end
      7: return shf(a, cnt, ov);
      8: return shf(a, -cnt, ov);
      9: return satf(sx(a) < 0 ? -sx(a) : sx(a), ov);
      10: return satf(-sx(a), ov);
      11: return nrmf(a);
      default: return 0;
    endcase
  endfunction

  task automatic issue(input logic [3:0] op, input logic [3:0] dst, input logic [3:0] sa,
                       input logic [3:0] sb, input bit ret, input logic [31:0] din, input bit clr);
    vld_i = 1; op_i = op; dst_i = dst; sa_i = sa; sb_i = sb; ret_i = ret; din_i = din; ovf_clr_i = clr;
    @(negedge clk);
  endtask

  task automatic idle(input bit clr);
    vld_i = 0; ret_i = 0; ovf_clr_i = clr;
    @(negedge clk);
  endtask

  task automatic readreg(input logic [3:0] r, output logic [31:0] v, output bit got);
    issue(0, 0, r, 0, 1, 0, 0);
    idle(0);
    got = rvld_o;
    v = rdata_o;
  endtask

  string names [12] = '{"R2 mov", "R2 ldi", "R3 add", "R3 sub", "R4 mul", "R5 mac",
                        "R5 msu", "R6 shl", "R6 shr", "R7 abs", "R7 neg", "R7 nrm"};

  task automatic run(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                     input logic [31:0] d, input bit order, input bit clr, input bit chkflag);
    bit eov;
    logic [31:0] e = model(op, a, b, d, eov);
    if (order) begin
      issue(1, 3, 0, 0, 0, d, clr); issue(1, 2, 0, 0, 0, b, 0); issue(1, 1, 0, 0, 0, a, 0);
    end else begin
      issue(1, 1, 0, 0, 0, a, clr); issue(1, 2, 0, 0, 0, b, 0); issue(1, 3, 0, 0, 0, d, 0);
    end
    issue(op, 3, 1, 2, 1, a, 0);
    idle(0);
    chk(rvld_o && rdata_o == e, $sformatf("%s R9 R10 a=%h b=%h d=%h", names[op], a, b, d), rdata_o, e);
    if (chkflag) chk(ovf_o == eov, $sformatf("%s flag R8 a=%h b=%h", names[op], a, b), 32'(ovf_o), 32'(eov));
  endtask

  logic [31:0] vals [10] = '{32'h0, 32'h1, 32'hFFFFFFFF, 32'h7FFFFFFF, 32'h80000000,
                             32'h00008000, 32'h00007FFF, 32'h40000000, 32'hFFFFFFE0, 32'h00000021};

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    bit got;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(ovf_o == 0, "R1 flag after reset", 32'(ovf_o), 0);
    chk(rvld_o == 0, "R1 rvld after reset", 32'(rvld_o), 0);
    for (int r = 0; r < 16; r++) begin
      readreg(r[3:0], v, got);
      chk(got && v == 0, $sformatf("R1 reg %0d after reset", r), v, 0);
    end

    for (int op = 0; op < 12; op++)
      for (int i = 0; i < 10; i++)
        for (int j = 0; j < 10; j++)
          run(op[3:0], vals[i], vals[j], vals[(i + j + op) % 10], j[0], 1'b1, 1'b1);

    run(2, 32'h7FFFFFFF, 32'h1, 0, 0, 1, 1);
    for (int k = 0; k < 3; k++) begin
      run(2, 32'h5, 32'h6, 0, k[0], 0, 0);
      chk(ovf_o == 1, "R8 flag stays set", 32'(ovf_o), 1);
    end
    idle(1);
    idle(0);
    chk(ovf_o == 0, "R8 flag cleared", 32'(ovf_o), 0);
    issue(10, 4, 0, 0, 1, 0, 0);
    vld_i = 0; ret_i = 0; ovf_clr_i = 1;
    @(negedge clk);
    chk(ovf_o == 0, "R8 pre-race flag", 32'(ovf_o), 0);
    issue(1, 1, 0, 0, 0, 32'h80000000, 0);
    issue(10, 4, 1, 0, 1, 0, 0);
    vld_i = 0; ret_i = 0; ovf_clr_i = 1;
    @(negedge clk);
    ovf_clr_i = 0;
    chk(ovf_o == 1, "R8 clamp beats clear", 32'(ovf_o), 1);
    chk(rvld_o && rdata_o == 32'h7FFFFFFF, "R7 neg min", rdata_o, 32'h7FFFFFFF);

    idle(1);
    issue(1, 6, 0, 0, 0, 32'hCAFE0001, 0);
    issue(1, 1, 0, 0, 0, 32'h11, 0);
    issue(2, 6, 1, 1, 1, 0, 0);
    idle(0);
    chk(rvld_o && rdata_o == 32'h22, "R9 returned sum", rdata_o, 32'h22);
    readreg(6, v, got);
    chk(got && v == 32'hCAFE0001, "R9 return leaves reg", v, 32'hCAFE0001);

    issue(1, 5, 0, 0, 0, 32'h000055AA, 0);
    issue(1, 1, 0, 0, 0, 32'h7FFFFFFF, 0);
    for (int op = 12; op < 16; op++) begin
      issue(op[3:0], 5, 1, 1, 1, 32'hFFFFFFFF, 0);
      idle(0);
      chk(rvld_o == 0, $sformatf("R11 op %0d returns nothing", op), 32'(rvld_o), 0);
      issue(op[3:0], 5, 1, 1, 0, 32'hFFFFFFFF, 0);
      idle(0);
      readreg(5, v, got);
      chk(got && v == 32'h55AA, $sformatf("R11 op %0d reg kept", op), v, 32'h55AA);
      chk(ovf_o == 0, $sformatf("R11 op %0d flag kept", op), 32'(ovf_o), 0);
    end

    issue(1, 7, 0, 0, 0, 32'h00010000, 0);
    issue(2, 7, 7, 7, 0, 0, 0);
    issue(2, 8, 7, 7, 1, 0, 0);
    idle(0);
    chk(rvld_o && rdata_o == 32'h00040000, "R10 chained forwarding", rdata_o, 32'h00040000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule